// File: doc/BRIEF.md
# Overcurrent Foldback Mode Controller

This block decides how hard a half-bridge PWM generator may drive once per switching cycle, based on a digitized primary current-sense reading in millivolts. It keeps a 12-bit saturating integrator that plays the part of a current-limit timing capacitor. The integrator climbs slowly while the current is low. It sinks in proportion to the overshoot while the current sits between two limits. It drops straight to a floor when the current passes the upper limit.

The integrator value is mapped onto three controls for the PWM generator. Above a knee it sets a duty-cycle ceiling that falls toward the minimum duty as the integrator falls. Below the knee the duty stays at the minimum and an oscillator divide ratio steps from 1 up to 5. An inhibit flag stops both primary drives after a severe overcurrent sample. Normal voltage-mode operation comes back as soon as a sample falls below the limit. There is no soft-start restart: the integrator just climbs back from where it is.

Top module: `ocp_foldback_ctrl`

## Requirements
- R1: After reset the integrator is at its upper clamp (4000), so `duty_ceil` reads 240, `osc_div` reads 1 and `drv_off` reads 0.
- R2: A valid sample below 100 mV raises the integrator by 32, saturating at the upper clamp of 4000.
- R3: A valid sample from 100 mV to 150 mV inclusive lowers the integrator by 4 × (sample − 100), saturating at the low clamp of 256.
- R4: A valid sample above 150 mV sets the integrator to the low clamp and raises `drv_off` one cycle after the strobe.
- R5: The first valid sample at or below 150 mV clears `drv_off`. The integrator then continues from its present value, with no restart to full duty.
- R6: When the integrator is at or above the knee of 2048, `duty_ceil` = min(8 + ((integrator − 2048) >> 3), 240). Below the knee it is the minimum duty of 8.
- R7: `osc_div` is 1 at or above 2048. It is 2 from 1600 to 2047, 3 from 1152 to 1599, 4 from 704 to 1151, and 5 below 704. It never leaves the range 1 to 5, and it differs from 1 only when the duty is at its minimum.
- R8: A cycle with `smp_stb` low, or with `smp_stb` high and `smp_ok` low, changes neither the integrator nor `drv_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe, once per switching cycle |
| smp_ok | input | 1 | Marks the sense value on this strobe as usable |
| smp_mv | input | 10 | Differential current-sense value in millivolts |
| duty_ceil | output | 8 | Maximum duty allowed to the PWM generator |
| osc_div | output | 3 | Oscillator divide ratio, 1 to 5 |
| drv_off | output | 1 | Inhibit for both primary drives |

## Verification
The properties assume that `smp_stb` is a single-cycle pulse. They also assume that `smp_mv` and `smp_ok` are steady in the cycle where the strobe is high. The integrator step checks compare one strobe against the cycle that follows it. The stimulus changes all inputs at the falling clock edge and drops the strobe after one cycle, so every sample is seen exactly once. The sample values range over the charge band, both ends of the proportional band and just past the upper limit. This moves the integrator across the knee, every divide step and both clamps.

// File: rtl/ocp_foldback_ctrl.sv
module ocp_foldback_ctrl #(
  parameter int SENSE_W     = 10,
  parameter int ACC_W       = 12,
  parameter int DUTY_W      = 8,
  parameter int LO_MV       = 100,
  parameter int HI_MV       = 150,
  parameter int CHARGE_STEP = 32,
  parameter int DIS_GAIN    = 4,
  parameter int CLAMP_HI    = 4000,
  parameter int CLAMP_LO    = 256,
  parameter int KNEE        = 2048,
  parameter int DUTY_SHIFT  = 3,
  parameter int DUTY_MIN    = 8,
  parameter int DUTY_MAX    = 240,
  parameter int DIV_MAX     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_stb,
  input  logic               smp_ok,
  input  logic [SENSE_W-1:0] smp_mv,
  output logic [DUTY_W-1:0]  duty_ceil,
  output logic [2:0]         osc_div,
  output logic               drv_off
);
  localparam int SUM_W = ACC_W + 1;
  localparam int STEP  = (KNEE - CLAMP_LO) / (DIV_MAX - 1);

  logic [ACC_W-1:0] acc, acc_nx;
  logic             hit, low_band, mid_band;
  logic [SUM_W-1:0] up, drop, floor_pt;

  assign hit      = smp_stb && smp_ok;
  assign low_band = smp_mv < SENSE_W'(LO_MV);
  assign mid_band = !low_band && (smp_mv <= SENSE_W'(HI_MV));
  assign up       = {1'b0, acc} + SUM_W'(CHARGE_STEP);
  assign drop     = SUM_W'(smp_mv - SENSE_W'(LO_MV)) * SUM_W'(DIS_GAIN);
  assign floor_pt = SUM_W'(CLAMP_LO) + drop;

  always_comb begin
    acc_nx = acc;
    if (hit) begin
      if (low_band)
        acc_nx = (up >= SUM_W'(CLAMP_HI)) ? ACC_W'(CLAMP_HI) : up[ACC_W-1:0];
      else if (mid_band)
        acc_nx = ({1'b0, acc} <= floor_pt) ? ACC_W'(CLAMP_LO) : acc - drop[ACC_W-1:0];
      else
        acc_nx = ACC_W'(CLAMP_LO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= ACC_W'(CLAMP_HI);
      drv_off <= 1'b0;
    end else begin
      acc <= acc_nx;
      if (hit) drv_off <= !low_band && !mid_band;
    end
  end

  logic [ACC_W-1:0] ramp;
  assign ramp = ((acc - ACC_W'(KNEE)) >> DUTY_SHIFT) + ACC_W'(DUTY_MIN);
  assign duty_ceil = (acc < ACC_W'(KNEE))     ? DUTY_W'(DUTY_MIN) :
                     (ramp > ACC_W'(DUTY_MAX)) ? DUTY_W'(DUTY_MAX) : ramp[DUTY_W-1:0];

  always_comb begin
    osc_div = 3'd1;
    for (int k = 0; k < DIV_MAX - 1; k++)
      if (acc < ACC_W'(KNEE - k * STEP)) osc_div = osc_div + 3'd1;
  end
endmodule

// File: rtl/ocp_foldback_chk.sv
module ocp_foldback_chk #(
  parameter int SENSE_W  = 10,
  parameter int ACC_W    = 12,
  parameter int DUTY_W   = 8,
  parameter int LO_MV    = 100,
  parameter int HI_MV    = 150,
  parameter int CLAMP_HI = 4000,
  parameter int CLAMP_LO = 256,
  parameter int DUTY_MIN = 8,
  parameter int DUTY_MAX = 240,
  parameter int DIV_MAX  = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               smp_stb,
  input logic               smp_ok,
  input logic [SENSE_W-1:0] smp_mv,
  input logic [ACC_W-1:0]   acc,
  input logic [DUTY_W-1:0]  duty_ceil,
  input logic [2:0]         osc_div,
  input logic               drv_off
);
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    osc_div >= 3'd1 && osc_div <= 3'(DIV_MAX)); // R7
  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    duty_ceil >= DUTY_W'(DUTY_MIN) && duty_ceil <= DUTY_W'(DUTY_MAX)); // R6
  AST_FOLD_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    osc_div != 3'd1 |-> duty_ceil == DUTY_W'(DUTY_MIN)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_stb && smp_ok) |=> $stable(acc) && $stable(drv_off)); // R8
  AST_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && smp_ok && smp_mv > SENSE_W'(HI_MV) |=> drv_off && acc == ACC_W'(CLAMP_LO)); // R4
  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && smp_ok && smp_mv <= SENSE_W'(HI_MV) |=> !drv_off); // R5
  AST_CHARGE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && smp_ok && smp_mv < SENSE_W'(LO_MV) && acc < ACC_W'(CLAMP_HI) |=> acc > $past(acc)); // R2
  AST_BAND_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb && smp_ok && smp_mv >= SENSE_W'(LO_MV) && smp_mv <= SENSE_W'(HI_MV) |=> acc <= $past(acc)); // R3
endmodule

bind ocp_foldback_ctrl ocp_foldback_chk #(
  .SENSE_W(SENSE_W), .ACC_W(ACC_W), .DUTY_W(DUTY_W), .LO_MV(LO_MV), .HI_MV(HI_MV),
  .CLAMP_HI(CLAMP_HI), .CLAMP_LO(CLAMP_LO), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX),
  .DIV_MAX(DIV_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_ok(smp_ok), .smp_mv(smp_mv),
  .acc(acc), .duty_ceil(duty_ceil), .osc_div(osc_div), .drv_off(drv_off)
);

// File: tb/sim_ocp_foldback_ctrl.sv
module sim_ocp_foldback_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_stb = 1'b0;
  logic       smp_ok = 1'b0;
  logic [9:0] smp_mv = '0;
  logic [7:0] duty_ceil;
  logic [2:0] osc_div;
  logic       drv_off;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ocp_foldback_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_ok(smp_ok), .smp_mv(smp_mv),
    .duty_ceil(duty_ceil), .osc_div(osc_div), .drv_off(drv_off)
  );

  // {ok, mv, duty, div, off}
  localparam int NV = 26;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 10'd120, 8'd240, 3'd1, 1'b0},  // R3 4000->3920
    {1'b1, 10'd150, 8'd217, 3'd1, 1'b0},  // R3 3720
    {1'b1, 10'd150, 8'd192, 3'd1, 1'b0},  // 3520
    {1'b1, 10'd100, 8'd192, 3'd1, 1'b0},  // zero excess
    {1'b1, 10'd99,  8'd196, 3'd1, 1'b0},  // R2 3552
    {1'b0, 10'd200, 8'd196, 3'd1, 1'b0},  // R8 invalid sample
    {1'b1, 10'd150, 8'd171, 3'd1, 1'b0},  // 3352
    {1'b1, 10'd150, 8'd146, 3'd1, 1'b0},  // 3152
    {1'b1, 10'd150, 8'd121, 3'd1, 1'b0},  // 2952
    {1'b1, 10'd150, 8'd96,  3'd1, 1'b0},  // 2752
    {1'b1, 10'd150, 8'd71,  3'd1, 1'b0},  // 2552
    {1'b1, 10'd150, 8'd46,  3'd1, 1'b0},  // 2352
    {1'b1, 10'd150, 8'd21,  3'd1, 1'b0},  // 2152
    {1'b1, 10'd150, 8'd8,   3'd2, 1'b0},  // R7 1952
    {1'b1, 10'd150, 8'd8,   3'd2, 1'b0},  // 1752
    {1'b1, 10'd150, 8'd8,   3'd3, 1'b0},  // 1552
    {1'b1, 10'd90,  8'd8,   3'd3, 1'b0},  // 1584
    {1'b1, 10'd150, 8'd8,   3'd3, 1'b0},  // 1384
    {1'b1, 10'd150, 8'd8,   3'd3, 1'b0},  // 1184
    {1'b1, 10'd150, 8'd8,   3'd4, 1'b0},  // 984
    {1'b1, 10'd150, 8'd8,   3'd4, 1'b0},  // 784
    {1'b1, 10'd150, 8'd8,   3'd5, 1'b0},  // 584
    {1'b1, 10'd150, 8'd8,   3'd5, 1'b0},  // 384
    {1'b1, 10'd150, 8'd8,   3'd5, 1'b0},  // floor 256
    {1'b1, 10'd151, 8'd8,   3'd5, 1'b1},  // R4
    {1'b1, 10'd0,   8'd8,   3'd5, 1'b0}   // R5 288
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic ok, input logic [9:0] mv);
    @(negedge clk);
    smp_stb = 1'b1; smp_ok = ok; smp_mv = mv;
    @(negedge clk);
    smp_stb = 1'b0; smp_ok = 1'b0;
  endtask

  task automatic expect3(input string tag, input int d, input int v, input int o);
    chk({tag, " duty (R6)"}, duty_ceil, d);
    chk({tag, " div (R7)"}, osc_div, v);
    chk({tag, " off (R4/R5)"}, drv_off, o);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect3("R1 reset", 240, 1, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][22], VEC[i][21:12]);
      expect3($sformatf("vec%0d R2 R3 R8", i), VEC[i][11:4], VEC[i][3:1], VEC[i][0]);
    end

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    expect3("R1 rerun reset", 240, 1, 0);

    apply(1'b1, 10'd50);
    chk("R2 charge at clamp", duty_ceil, 240);
    apply(1'b1, 10'd150);
    chk("R2 clamp held at 4000", duty_ceil, 227);

    @(negedge clk);
    smp_ok = 1'b1; smp_mv = 10'd200;
    @(negedge clk);
    smp_ok = 1'b0;
    @(negedge clk);
    expect3("R8 no strobe", 227, 1, 0);

    apply(1'b1, 10'd200);
    expect3("R4 trip", 8, 5, 1);
    apply(1'b1, 10'd130);
    expect3("R5 resume at floor R3", 8, 5, 0);
    apply(1'b1, 10'd99);
    expect3("R5 no restart", 8, 5, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule